// File: doc/BRIEF.md
# Opcode Injection Bus Controller

This block sits between an 8-bit CPU bus with active-low memory request, I/O request, read and write strobes and a slow host controller. While injection is armed, every memory read cycle that the CPU starts is frozen with the active-low wait line. The read strobe towards memory is gated off. A byte supplied by the host is placed on a tri-stateable driver in place of memory data. The host offers that byte with a one-clock valid strobe, and the block then lets the CPU finish the cycle. Writes always pass straight to RAM. A copy loop can therefore be fed opcodes by the host while its stores land in real memory.

After feeding an instruction, the host can load a bypass count. The block then leaves exactly that many following memory or I/O request cycles untouched, so the instruction can reach real memory or peripherals. Injection returns by itself when the count runs out. A second register captures the values the CPU drives during write cycles, which lets the host read CPU state. To stop injecting, the host feeds a jump and then drops the enable, after which reads reach memory normally. All bus inputs are taken as synchronous to the block clock.

Top module: `opstuff_ctl`

## Requirements
- R1: After reset, `cpu_wait_n` is 1, `byte_req` is 0, `drv_oe` is 0, `byp_active` is 0 and `drv_data` and `snoop_data` are 0.
- R2: When `inj_en` is 1 and the bypass count is zero, the start of a memory read makes `cpu_wait_n` 0 and `byte_req` 1 from the next clock. A memory read means `cpu_mreq_n`=0, `cpu_rd_n`=0 and `cpu_iorq_n`=1. Both hold until the host answers.
- R3: `host_valid` seen on a clock while `byte_req` is 1 releases `cpu_wait_n` on the next clock and loads `host_byte` into `drv_data`. `host_valid` at any other time leaves `drv_data` and `cpu_wait_n` unchanged.
- R4: `mem_rd_n` is 1 whenever `inj_en` is 1 with a zero bypass count, and for the whole of an injected read. Otherwise it equals `cpu_rd_n`.
- R5: `drv_oe` is 1 from the clock after an injected read starts until the clock after the read or memory request strobe goes high. It is never set by a write, an I/O cycle or a non-injected read.
- R6: A clock with `byp_load`=1 loads `byp_count` into the bypass counter, and this load wins over a decrement. `byp_active` is 1 exactly while the counter is nonzero.
- R7: Each ending of a request cycle (either request strobe rising) that was not injected decrements a nonzero bypass counter by one. The ending of an injected read is not counted, even if the counter was loaded during its stall.
- R8: While the bypass counter is nonzero, reads are not stalled and reach memory. Once the counter reaches zero, the next memory read is injected again.
- R9: Write cycles are never stalled. On every clock where `cpu_wr_n` is 0 with a request active, `snoop_data` captures `cpu_data_in`.
- R10: With `inj_en` at 0, no cycle is stalled and `mem_rd_n` follows `cpu_rd_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inj_en | input | 1 | Host enable for injection |
| cpu_mreq_n | input | 1 | CPU memory request, active low |
| cpu_iorq_n | input | 1 | CPU I/O request, active low |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| cpu_data_in | input | DW | Data bus as seen by the block |
| host_valid | input | 1 | Host strobe: byte on host_byte is ready |
| host_byte | input | DW | Byte to feed the CPU |
| byp_load | input | 1 | Load the bypass counter |
| byp_count | input | CW | Number of cycles to pass through |
| cpu_wait_n | output | 1 | Wait request to the CPU, active low |
| mem_rd_n | output | 1 | Gated read strobe to memory |
| drv_oe | output | 1 | Output enable of the data bus driver |
| drv_data | output | DW | Byte presented by the driver |
| snoop_data | output | DW | Last value driven by the CPU in a write |
| byte_req | output | 1 | Status: waiting for a host byte |
| byp_active | output | 1 | Bypass counter is nonzero |

## Verification
The hardest case to reach is a bypass count loaded while an injected fetch is still stalled. The injected cycle then ends with a nonzero counter but must not use up one of the passes. The random stimulus sometimes loads the counter in the middle of a stall before answering. It then mixes reads, writes and I/O cycles so the counter is seen counting down to zero and injection is seen resuming, with the expected count kept in the bench. Directed cases add host strobes outside a stall and a load on a counter that is already nonzero.

// File: rtl/opstuff_ctl.sv
module opstuff_ctl #(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inj_en,
  input  logic          cpu_mreq_n,
  input  logic          cpu_iorq_n,
  input  logic          cpu_rd_n,
  input  logic          cpu_wr_n,
  input  logic [DW-1:0] cpu_data_in,
  input  logic          host_valid,
  input  logic [DW-1:0] host_byte,
  input  logic          byp_load,
  input  logic [CW-1:0] byp_count,
  output logic          cpu_wait_n,
  output logic          mem_rd_n,
  output logic          drv_oe,
  output logic [DW-1:0] drv_data,
  output logic [DW-1:0] snoop_data,
  output logic          byte_req,
  output logic          byp_active
);
  logic [CW-1:0] cnt_q;
  logic          stall_q, cyc_inj_q, qrd_q, req_q, oe_q;
  logic [DW-1:0] drv_q, snoop_q;

  wire qrd      = !cpu_mreq_n && !cpu_rd_n && cpu_iorq_n;
  wire req      = !cpu_mreq_n || !cpu_iorq_n;
  wire armed    = inj_en && (cnt_q == '0);
  wire rd_start = qrd && !qrd_q;
  wire req_end  = req_q && !req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q   <= 1'b0;
      cyc_inj_q <= 1'b0;
      oe_q      <= 1'b0;
      qrd_q     <= 1'b0;
      req_q     <= 1'b0;
      drv_q     <= '0;
    end else begin
      qrd_q <= qrd;
      req_q <= req;
      if (rd_start && armed) begin
        stall_q   <= 1'b1;
        cyc_inj_q <= 1'b1;
        oe_q      <= 1'b1;
      end else begin
        if (stall_q && host_valid) begin
          stall_q <= 1'b0;
          drv_q   <= host_byte;
        end
        if (!qrd) oe_q <= 1'b0;
        if (req_end) cyc_inj_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (byp_load)
      cnt_q <= byp_count;
    else if (req_end && !cyc_inj_q && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      snoop_q <= '0;
    else if (!cpu_wr_n && req)
      snoop_q <= cpu_data_in;
  end

  assign cpu_wait_n = !stall_q;
  assign byte_req   = stall_q;
  assign mem_rd_n   = cpu_rd_n | armed | cyc_inj_q;
  assign drv_oe     = oe_q;
  assign drv_data   = drv_q;
  assign snoop_data = snoop_q;
  assign byp_active = (cnt_q != '0);
endmodule

// File: rtl/opstuff_ctl_chk.sv
module opstuff_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic inj_en,
  input logic cpu_mreq_n,
  input logic cpu_iorq_n,
  input logic cpu_rd_n,
  input logic host_valid,
  input logic cpu_wait_n,
  input logic mem_rd_n,
  input logic drv_oe,
  input logic byp_active
);
  // R2
  wait_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_wait_n) |-> $past(!cpu_mreq_n && !cpu_rd_n && cpu_iorq_n && inj_en && !byp_active));

  // R3
  wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_wait_n) |-> $past(host_valid));

  // R4
  rd_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_en && !byp_active) |-> mem_rd_n);

  // R5
  oe_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_oe) |-> $past(!cpu_mreq_n && !cpu_rd_n && cpu_iorq_n));

  // R10
  no_stall_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inj_en && !drv_oe && cpu_wait_n) |-> (mem_rd_n == cpu_rd_n));
endmodule

bind opstuff_ctl opstuff_ctl_chk u_chk (.*);

// File: tb/opstuff_ctl_tb.sv
`timescale 1ns/1ps
module opstuff_ctl_tb;
  localparam int DW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inj_en = 1'b0;
  logic mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [DW-1:0] dbus = '0, hbyte = '0;
  logic hvalid = 1'b0, bload = 1'b0;
  logic [CW-1:0] bcount = '0;
  logic wait_n, mrd_n, oe, breq, bact;
  logic [DW-1:0] ddata, sdata;

  int checks = 0, errors = 0;
  int exp_cnt = 0;
  logic [DW-1:0] exp_drv = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  opstuff_ctl #(.DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .inj_en(inj_en),
    .cpu_mreq_n(mreq_n), .cpu_iorq_n(iorq_n), .cpu_rd_n(rd_n), .cpu_wr_n(wr_n),
    .cpu_data_in(dbus), .host_valid(hvalid), .host_byte(hbyte),
    .byp_load(bload), .byp_count(bcount),
    .cpu_wait_n(wait_n), .mem_rd_n(mrd_n), .drv_oe(oe), .drv_data(ddata),
    .snoop_data(sdata), .byte_req(breq), .byp_active(bact));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit will_inject();
    return inj_en && exp_cnt == 0;
  endfunction

  function automatic int after_end(input int c, input bit injected);
    return (!injected && c > 0) ? c - 1 : c;
  endfunction

  task automatic load_byp(input int n);
    @(negedge clk); bload = 1'b1; bcount = CW'(n);
    @(negedge clk); bload = 1'b0;
    exp_cnt = n;
    chk(bact == (n != 0), "R6 load", bact, n != 0);
  endtask

  task automatic mem_read(input logic [DW-1:0] hb, input bit load_mid, input int nload);
    bit inj;
    inj = will_inject();
    @(negedge clk); mreq_n = 1'b0; rd_n = 1'b0;
    #0.5;
    chk(mrd_n == inj, "R4 read gate", mrd_n, inj);
    @(negedge clk);
    chk(wait_n == !inj, inj ? "R2 stall" : "R8 R10 no stall", wait_n, !inj);
    chk(breq == inj, "R2 byte_req", breq, inj);
    chk(oe == inj, "R5 oe on", oe, inj);
    if (inj) begin
      int hold = $urandom_range(0, 3);
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk(!wait_n, "R2 hold", wait_n, 0);
      end
      if (load_mid) begin
        bload = 1'b1; bcount = CW'(nload);
        @(negedge clk); bload = 1'b0; exp_cnt = nload;
      end
      hvalid = 1'b1; hbyte = hb;
      @(negedge clk); hvalid = 1'b0;
      exp_drv = hb;
      chk(wait_n, "R3 release", wait_n, 1);
      chk(ddata == exp_drv, "R3 byte", ddata, exp_drv);
      chk(mrd_n, "R4 hold gate", mrd_n, 1);
    end
    mreq_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    chk(!oe, "R5 oe off", oe, 0);
    exp_cnt = after_end(exp_cnt, inj);
    chk(bact == (exp_cnt != 0), "R7 count", bact, exp_cnt != 0);
  endtask

  task automatic mem_write(input logic [DW-1:0] v);
    @(negedge clk); mreq_n = 1'b0; wr_n = 1'b0; dbus = v;
    @(negedge clk);
    chk(wait_n, "R9 no stall", wait_n, 1);
    chk(!oe, "R5 no oe on write", oe, 0);
    wr_n = 1'b1; mreq_n = 1'b1;
    @(negedge clk);
    chk(sdata == v, "R9 snoop", sdata, v);
    exp_cnt = after_end(exp_cnt, 1'b0);
    chk(bact == (exp_cnt != 0), "R7 count", bact, exp_cnt != 0);
  endtask

  task automatic io_cycle(input bit wr, input logic [DW-1:0] v);
    @(negedge clk); iorq_n = 1'b0; dbus = v;
    if (wr) wr_n = 1'b0; else rd_n = 1'b0;
    @(negedge clk);
    chk(wait_n, "R2 io no stall", wait_n, 1);
    chk(!oe, "R5 no oe on io", oe, 0);
    iorq_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    if (wr) chk(sdata == v, "R9 io snoop", sdata, v);
    exp_cnt = after_end(exp_cnt, 1'b0);
    chk(bact == (exp_cnt != 0), "R7 count", bact, exp_cnt != 0);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(wait_n && !breq && !oe && !bact, "R1 reset outputs", {wait_n, breq, oe, bact}, 4'b1000);
    chk(ddata == 0 && sdata == 0, "R1 reset data", ddata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mem_read(8'h11, 1'b0, 0);
    chk(mrd_n == rd_n, "R10 follow", mrd_n, rd_n);
    inj_en = 1'b1;
    @(negedge clk);
    chk(mrd_n, "R4 armed idle", mrd_n, 1);
    hvalid = 1'b1; hbyte = 8'h5A;
    @(negedge clk); hvalid = 1'b0;
    chk(ddata == exp_drv && wait_n, "R3 ignored strobe", ddata, exp_drv);
    mem_read(8'hED, 1'b0, 0);
    mem_read(8'hA0, 1'b1, 2);
    mem_write(8'h3C);
    mem_read(8'h00, 1'b0, 0);
    mem_read(8'h77, 1'b0, 0);
    load_byp(3);
    load_byp(1);
    io_cycle(1'b1, 8'h42);
    mem_read(8'hC3, 1'b0, 0);
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) mem_read(DW'($urandom), $urandom_range(0, 3) == 0, $urandom_range(1, 4));
      else if (op < 6) mem_write(DW'($urandom));
      else if (op < 8) io_cycle($urandom_range(0, 1) == 1, DW'($urandom));
      else if (op == 8) load_byp($urandom_range(0, 5));
      else begin
        @(negedge clk); inj_en = ($urandom_range(0, 3) != 0);
      end
    end
    inj_en = 1'b0;
    mem_read(8'h00, 1'b0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule